// File: doc/BRIEF.md
# Deblocking Boundary Strength Generator

This block grades every 4-sample edge segment of a 16x16 luma macroblock for the deblocking loop filter. It takes side information for each 4x4 block of the current macroblock. It also takes the same information for the column of blocks to its left and the row of blocks above it. From this it returns a 3-bit strength for each of the 16 vertical and 16 horizontal segments. Strength 0 means the segment is left alone. Values 1 to 4 give increasing filter strength.

The per-block record holds five fields: an intra flag, a coded-residual flag, two motion vector components in quarter-sample units, and a reference index. The macroblock-level inputs are:
- a skip flag;
- a zero-coded-block-pattern flag;
- a partition shape;
- two flags that say whether the left and top neighbours exist in the same slice.

Whole groups of edges are pruned for skipped macroblocks and for partitioned macroblocks without residual. The rules are checked strictly from strength 4 down to strength 0, and the first rule that matches decides the strength.

Blocks are numbered in raster order, index = row*4 + column. Vertical edge e (e = 0..3) lies on the left side of block column e. Its segment for block row r has index e*4 + r. Horizontal edge e lies on the top side of block row e. Its segment for block column c has index e*4 + c. Edge 0 in either direction is the macroblock boundary. On that edge the far-side block comes from the left or top neighbour input, using the same row or column number. Results are registered, and `out_valid` rises one cycle after `in_valid`.

Top module: `dbk_bs_gen`

## Requirements
- R1: A block record occupies BLKW = 2+2*MVW+REFW bits, laid out as follows:
  - bit 0: intra flag;
  - bit 1: coded-residual flag;
  - bits [2 +: MVW]: horizontal motion vector, two's complement;
  - bits [2+MVW +: MVW]: vertical motion vector, two's complement;
  - bits [2+2*MVW +: REFW]: reference index.

  On an enabled edge-0 segment, if either side is intra, the strength is 4.
- R2: On an enabled internal segment (edge 1..3), if either side is intra, the strength is 3.
- R3: If neither side is intra and either side has its coded-residual flag set, the strength is 2.
- R4: If neither side is intra and neither has residual, but the reference indices differ, the strength is 1.
- R5: If neither side is intra, neither has residual and the references match, the strength is 1 when either motion vector component differs by 4 or more in absolute value. A difference of 3 or less gives 0.
- R6: Rules apply in priority order 4, 3, 2, 1, 0. For example, intra together with residual still gives 4 or 3, and a segment matching no rule gives 0.
- R7: When `left_avail` is 0, every vertical edge-0 segment is 0. When `top_avail` is 0, every horizontal edge-0 segment is 0.
- R8: When `mb_skip` is 1, every internal segment in both directions is 0. Edge-0 segments are still graded.
- R9: This requirement applies when `cbp_zero` is 1 and `mb_skip` is 0. The `part_shape` encoding is 0 = 16x16, 1 = 16x8, 2 = 8x16, 3 = 8x8.
  - Shape 1: the only internal edge kept is horizontal edge 2.
  - Shape 2: the only internal edge kept is vertical edge 2.
  - Shapes 0 and 3: no edge is pruned.
  - `cbp_zero` at 0: no edge is pruned.
- R10: Bit e of `edge_mask_v` is 1 exactly when at least one of vertical edge e's four segments is nonzero. `edge_mask_h` follows the same rule for horizontal edges.
- R11: Strengths and masks for an input set appear on the outputs in the cycle after `in_valid`, and `out_valid` is 1 in that cycle. While `in_valid` is 0, the input values have no effect: `out_valid` drops and the outputs hold their last values.
- R12: After reset, `out_valid`, all strengths and both masks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input set is valid this cycle |
| cur_blk | input | 16*BLKW (416) | Current macroblock block records, block b at [b*BLKW +: BLKW] |
| left_blk | input | 4*BLKW (104) | Left neighbour column, row r at [r*BLKW +: BLKW] |
| top_blk | input | 4*BLKW (104) | Top neighbour row, column c at [c*BLKW +: BLKW] |
| left_avail | input | 1 | Left neighbour exists in the same slice |
| top_avail | input | 1 | Top neighbour exists in the same slice |
| mb_skip | input | 1 | Current macroblock is skipped |
| cbp_zero | input | 1 | Current macroblock has zero coded block pattern |
| part_shape | input | 2 | Partition shape: 0 16x16, 1 16x8, 2 8x16, 3 8x8 |
| out_valid | output | 1 | Result valid |
| bs_v | output | 48 | Vertical segment strengths, segment s at [s*3 +: 3] |
| bs_h | output | 48 | Horizontal segment strengths, segment s at [s*3 +: 3] |
| edge_mask_v | output | 4 | Vertical edges with any nonzero strength |
| edge_mask_h | output | 4 | Horizontal edges with any nonzero strength |

## Verification
Any fault in the strength logic is visible on the very next `out_valid` cycle, because the block has a single register stage. A wrong strength is then confined to the segment index that names the faulty rule or edge position. Faults in the pruning decode reach the ports differently: a wrong value for skip, shape or availability zeroes or restores a whole edge, both in the four segments and in the matching mask bit. A stuck output register shows up in two ways. The outputs fail to hold across idle cycles, or the second of two back-to-back input sets returns the first set's result.

// File: rtl/dbk_bs_pkg.sv
package dbk_bs_pkg;

  typedef enum logic [1:0] {
    SHAPE_16X16 = 2'd0,
    SHAPE_16X8  = 2'd1,
    SHAPE_8X16  = 2'd2,
    SHAPE_8X8   = 2'd3
  } shape_e;

  localparam int BS_W = 3;

  localparam logic [BS_W-1:0] BS_NONE     = 3'd0;
  localparam logic [BS_W-1:0] BS_MOTION   = 3'd1;
  localparam logic [BS_W-1:0] BS_RESIDUAL = 3'd2;
  localparam logic [BS_W-1:0] BS_INTRA_IN = 3'd3;
  localparam logic [BS_W-1:0] BS_INTRA_MB = 3'd4;

endpackage

// File: rtl/dbk_bs_seg_rule.sv
module dbk_bs_seg_rule
  import dbk_bs_pkg::*;
#(
  parameter int MVW    = 10,
  parameter int REFW   = 4,
  parameter int MV_THR = 4,
  localparam int BLKW  = 2 + 2*MVW + REFW
) (
  input  logic [BLKW-1:0] p_blk,
  input  logic [BLKW-1:0] q_blk,
  input  logic            mb_edge,
  input  logic            edge_en,
  output logic [BS_W-1:0] bs
);

  localparam int MXO = 2;
  localparam int MYO = 2 + MVW;
  localparam int RFO = 2 + 2*MVW;

  logic          any_intra;
  logic          any_resid;
  logic          ref_diff;
  logic [MVW:0]  dx;
  logic [MVW:0]  dy;
  logic [MVW:0]  adx;
  logic [MVW:0]  ady;
  logic          mv_far;

  assign any_intra = p_blk[0] | q_blk[0];
  assign any_resid = p_blk[1] | q_blk[1];
  assign ref_diff  = p_blk[RFO +: REFW] != q_blk[RFO +: REFW];

  // sign-extended component differences, one bit wider than the vectors
  assign dx = {p_blk[MXO+MVW-1], p_blk[MXO +: MVW]} - {q_blk[MXO+MVW-1], q_blk[MXO +: MVW]};
  assign dy = {p_blk[MYO+MVW-1], p_blk[MYO +: MVW]} - {q_blk[MYO+MVW-1], q_blk[MYO +: MVW]};

  assign adx = dx[MVW] ? (~dx + 1'b1) : dx;
  assign ady = dy[MVW] ? (~dy + 1'b1) : dy;

  assign mv_far = (adx >= (MVW+1)'(MV_THR)) | (ady >= (MVW+1)'(MV_THR));

  always_comb begin
    if (!edge_en) begin
      bs = BS_NONE;
    end else if (any_intra) begin
      bs = mb_edge ? BS_INTRA_MB : BS_INTRA_IN;
    end else if (any_resid) begin
      bs = BS_RESIDUAL;
    end else if (ref_diff || mv_far) begin
      bs = BS_MOTION;
    end else begin
      bs = BS_NONE;
    end
  end

endmodule

// File: rtl/dbk_bs_edge_prune.sv
module dbk_bs_edge_prune
  import dbk_bs_pkg::*;
#(
  parameter int GRID = 4
) (
  input  logic            mb_skip,
  input  logic            cbp_zero,
  input  logic [1:0]      part_shape,
  input  logic            left_avail,
  input  logic            top_avail,
  output logic [GRID-1:0] en_v,
  output logic [GRID-1:0] en_h
);

  localparam int HALF = GRID / 2;

  logic bare_16x8;
  logic bare_8x16;

  assign bare_16x8 = cbp_zero & (shape_e'(part_shape) == SHAPE_16X8);
  assign bare_8x16 = cbp_zero & (shape_e'(part_shape) == SHAPE_8X16);

  for (genvar e = 0; e < GRID; e++) begin : g_edge
    if (e == 0) begin : g_outer
      assign en_v[e] = left_avail;
      assign en_h[e] = top_avail;
    end else if (e == HALF) begin : g_split
      // partition boundary: kept for the matching orientation only
      assign en_v[e] = ~mb_skip & ~bare_16x8;
      assign en_h[e] = ~mb_skip & ~bare_8x16;
    end else begin : g_inner
      assign en_v[e] = ~mb_skip & ~bare_16x8 & ~bare_8x16;
      assign en_h[e] = ~mb_skip & ~bare_16x8 & ~bare_8x16;
    end
  end

endmodule

// File: rtl/dbk_bs_out_stage.sv
module dbk_bs_out_stage
  import dbk_bs_pkg::*;
#(
  parameter int GRID = 4,
  localparam int NSEG = GRID * GRID,
  localparam int BSV_W = NSEG * BS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [BSV_W-1:0] bs_v_d,
  input  logic [BSV_W-1:0] bs_h_d,
  output logic             out_valid,
  output logic [BSV_W-1:0] bs_v_q,
  output logic [BSV_W-1:0] bs_h_q,
  output logic [GRID-1:0]  mask_v_q,
  output logic [GRID-1:0]  mask_h_q
);

  logic [GRID-1:0] mask_v_d;
  logic [GRID-1:0] mask_h_d;

  always_comb begin
    for (int e = 0; e < GRID; e++) begin
      mask_v_d[e] = 1'b0;
      mask_h_d[e] = 1'b0;
      for (int s = 0; s < GRID; s++) begin
        mask_v_d[e] = mask_v_d[e] | (|bs_v_d[(e*GRID+s)*BS_W +: BS_W]);
        mask_h_d[e] = mask_h_d[e] | (|bs_h_d[(e*GRID+s)*BS_W +: BS_W]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bs_v_q   <= '0;
      bs_h_q   <= '0;
      mask_v_q <= '0;
      mask_h_q <= '0;
    end else if (in_valid) begin
      bs_v_q   <= bs_v_d;
      bs_h_q   <= bs_h_d;
      mask_v_q <= mask_v_d;
      mask_h_q <= mask_h_d;
    end
  end

endmodule

// File: rtl/dbk_bs_gen.sv
module dbk_bs_gen
  import dbk_bs_pkg::*;
#(
  parameter int GRID   = 4,
  parameter int MVW    = 10,
  parameter int REFW   = 4,
  parameter int MV_THR = 4,
  localparam int BLKW  = 2 + 2*MVW + REFW,
  localparam int NSEG  = GRID * GRID,
  localparam int BSV_W = NSEG * BS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [NSEG*BLKW-1:0] cur_blk,
  input  logic [GRID*BLKW-1:0] left_blk,
  input  logic [GRID*BLKW-1:0] top_blk,
  input  logic                 left_avail,
  input  logic                 top_avail,
  input  logic                 mb_skip,
  input  logic                 cbp_zero,
  input  logic [1:0]           part_shape,
  output logic                 out_valid,
  output logic [BSV_W-1:0]     bs_v,
  output logic [BSV_W-1:0]     bs_h,
  output logic [GRID-1:0]      edge_mask_v,
  output logic [GRID-1:0]      edge_mask_h
);

  logic [1:0]       rst_pipe;
  logic             rst_n_sync;
  logic [GRID-1:0]  en_v;
  logic [GRID-1:0]  en_h;
  logic [BSV_W-1:0] bs_v_d;
  logic [BSV_W-1:0] bs_h_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_n_sync = rst_pipe[1];

  dbk_bs_edge_prune #(.GRID(GRID)) u_prune (
    .mb_skip    (mb_skip),
    .cbp_zero   (cbp_zero),
    .part_shape (part_shape),
    .left_avail (left_avail),
    .top_avail  (top_avail),
    .en_v       (en_v),
    .en_h       (en_h)
  );

  for (genvar e = 0; e < GRID; e++) begin : g_e
    for (genvar s = 0; s < GRID; s++) begin : g_s
      logic [BLKW-1:0] v_p;
      logic [BLKW-1:0] h_p;

      if (e == 0) begin : g_nb
        assign v_p = left_blk[s*BLKW +: BLKW];
        assign h_p = top_blk[s*BLKW +: BLKW];
      end else begin : g_in
        assign v_p = cur_blk[(s*GRID+e-1)*BLKW +: BLKW];
        assign h_p = cur_blk[((e-1)*GRID+s)*BLKW +: BLKW];
      end

      dbk_bs_seg_rule #(.MVW(MVW), .REFW(REFW), .MV_THR(MV_THR)) u_v (
        .p_blk   (v_p),
        .q_blk   (cur_blk[(s*GRID+e)*BLKW +: BLKW]),
        .mb_edge (e == 0),
        .edge_en (en_v[e]),
        .bs      (bs_v_d[(e*GRID+s)*BS_W +: BS_W])
      );

      dbk_bs_seg_rule #(.MVW(MVW), .REFW(REFW), .MV_THR(MV_THR)) u_h (
        .p_blk   (h_p),
        .q_blk   (cur_blk[(e*GRID+s)*BLKW +: BLKW]),
        .mb_edge (e == 0),
        .edge_en (en_h[e]),
        .bs      (bs_h_d[(e*GRID+s)*BS_W +: BS_W])
      );
    end
  end

  dbk_bs_out_stage #(.GRID(GRID)) u_out (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .in_valid  (in_valid),
    .bs_v_d    (bs_v_d),
    .bs_h_d    (bs_h_d),
    .out_valid (out_valid),
    .bs_v_q    (bs_v),
    .bs_h_q    (bs_h),
    .mask_v_q  (edge_mask_v),
    .mask_h_q  (edge_mask_h)
  );

endmodule

// File: rtl/dbk_bs_gen_chk.sv
module dbk_bs_gen_chk
  import dbk_bs_pkg::*;
#(
  parameter int GRID = 4,
  localparam int NSEG = GRID * GRID,
  localparam int BSV_W = NSEG * BS_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             mb_skip,
  input logic             left_avail,
  input logic             top_avail,
  input logic             out_valid,
  input logic [BSV_W-1:0] bs_v,
  input logic [BSV_W-1:0] bs_h,
  input logic [GRID-1:0]  edge_mask_v,
  input logic [GRID-1:0]  edge_mask_h
);

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r11_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(bs_v) && $stable(bs_h) && $stable(edge_mask_v) && $stable(edge_mask_h)));

  a_r8_skip_internal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mb_skip) |=> (edge_mask_v[GRID-1:1] == '0 && edge_mask_h[GRID-1:1] == '0));

  a_r7_no_left: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !left_avail) |=> (bs_v[GRID*BS_W-1:0] == '0));

  a_r7_no_top: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !top_avail) |=> (bs_h[GRID*BS_W-1:0] == '0));

  for (genvar e = 0; e < GRID; e++) begin : g_ce
    a_r10_mask_v: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (edge_mask_v[e] == (bs_v[e*GRID*BS_W +: GRID*BS_W] != '0)));
    a_r10_mask_h: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (edge_mask_h[e] == (bs_h[e*GRID*BS_W +: GRID*BS_W] != '0)));
    for (genvar s = 0; s < GRID; s++) begin : g_cs
      if (e == 0) begin : g_mb
        // R1: a boundary segment never takes the internal intra grade
        a_r1_no_grade3_v: assert property (@(posedge clk) disable iff (!rst_n)
          out_valid |-> (bs_v[s*BS_W +: BS_W] != BS_INTRA_IN));
        a_r1_no_grade3_h: assert property (@(posedge clk) disable iff (!rst_n)
          out_valid |-> (bs_h[s*BS_W +: BS_W] != BS_INTRA_IN));
      end else begin : g_int
        // R2: an internal segment never takes the boundary intra grade
        a_r2_no_grade4_v: assert property (@(posedge clk) disable iff (!rst_n)
          out_valid |-> (bs_v[(e*GRID+s)*BS_W +: BS_W] <= BS_INTRA_IN));
        a_r2_no_grade4_h: assert property (@(posedge clk) disable iff (!rst_n)
          out_valid |-> (bs_h[(e*GRID+s)*BS_W +: BS_W] <= BS_INTRA_IN));
      end
    end
  end

endmodule

bind dbk_bs_gen dbk_bs_gen_chk #(.GRID(GRID)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .in_valid    (in_valid),
  .mb_skip     (mb_skip),
  .left_avail  (left_avail),
  .top_avail   (top_avail),
  .out_valid   (out_valid),
  .bs_v        (bs_v),
  .bs_h        (bs_h),
  .edge_mask_v (edge_mask_v),
  .edge_mask_h (edge_mask_h)
);

// File: tb/dbk_bs_gen_bench.sv
module dbk_bs_gen_bench;

  localparam int GRID = 4;
  localparam int MVW  = 10;
  localparam int REFW = 4;
  localparam int BLKW = 2 + 2*MVW + REFW;
  localparam int NSEG = GRID * GRID;
  localparam int BSVW = NSEG * 3;

  logic                 clk;
  logic                 rst_n;
  logic                 in_valid;
  logic [NSEG*BLKW-1:0] cur_blk;
  logic [GRID*BLKW-1:0] left_blk;
  logic [GRID*BLKW-1:0] top_blk;
  logic                 left_avail;
  logic                 top_avail;
  logic                 mb_skip;
  logic                 cbp_zero;
  logic [1:0]           part_shape;
  logic                 out_valid;
  logic [BSVW-1:0]      bs_v;
  logic [BSVW-1:0]      bs_h;
  logic [GRID-1:0]      edge_mask_v;
  logic [GRID-1:0]      edge_mask_h;

  dbk_bs_gen u_dbk_bs_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .cur_blk(cur_blk), .left_blk(left_blk), .top_blk(top_blk),
    .left_avail(left_avail), .top_avail(top_avail),
    .mb_skip(mb_skip), .cbp_zero(cbp_zero), .part_shape(part_shape),
    .out_valid(out_valid), .bs_v(bs_v), .bs_h(bs_h),
    .edge_mask_v(edge_mask_v), .edge_mask_h(edge_mask_h)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic [BSVW-1:0] v;
    logic [BSVW-1:0] h;
    logic [GRID-1:0] mv;
    logic [GRID-1:0] mh;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  logic [BLKW-1:0] s_cur [NSEG];
  logic [BLKW-1:0] s_left[GRID];
  logic [BLKW-1:0] s_top [GRID];
  logic s_lav, s_tav, s_skip, s_cbp0;
  logic [1:0] s_shape;

  function automatic logic [BLKW-1:0] mk(bit intra, bit resid, int mx, int my, int rf);
    logic [BLKW-1:0] b;
    b = '0;
    b[0] = intra;
    b[1] = resid;
    b[2 +: MVW] = MVW'(mx);
    b[2+MVW +: MVW] = MVW'(my);
    b[2+2*MVW +: REFW] = REFW'(rf);
    return b;
  endfunction

  function automatic int iabs(int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic logic [2:0] grade(logic [BLKW-1:0] a, logic [BLKW-1:0] b, bit outer, bit kept);
    int ax, ay, bx, by;
    ax = int'($signed(a[2 +: MVW]));
    ay = int'($signed(a[2+MVW +: MVW]));
    bx = int'($signed(b[2 +: MVW]));
    by = int'($signed(b[2+MVW +: MVW]));
    if (!kept) return 3'd0;
    if (a[0] || b[0]) return outer ? 3'd4 : 3'd3;
    if (a[1] || b[1]) return 3'd2;
    if (a[2+2*MVW +: REFW] != b[2+2*MVW +: REFW]) return 3'd1;
    if (iabs(ax - bx) >= 4 || iabs(ay - by) >= 4) return 3'd1;
    return 3'd0;
  endfunction

  // dir 0 = vertical, 1 = horizontal
  function automatic bit kept(bit dir, int e);
    if (e == 0) return dir ? s_tav : s_lav;
    if (s_skip) return 1'b0;
    if (s_cbp0 && s_shape == 2'd1) return dir && (e == 2);
    if (s_cbp0 && s_shape == 2'd2) return !dir && (e == 2);
    return 1'b1;
  endfunction

  task automatic send(string tag);
    exp_t x;
    @(negedge clk);
    for (int b = 0; b < NSEG; b++) cur_blk[b*BLKW +: BLKW] = s_cur[b];
    for (int r = 0; r < GRID; r++) begin
      left_blk[r*BLKW +: BLKW] = s_left[r];
      top_blk[r*BLKW +: BLKW]  = s_top[r];
    end
    left_avail = s_lav; top_avail = s_tav; mb_skip = s_skip;
    cbp_zero = s_cbp0; part_shape = s_shape; in_valid = 1'b1;
    x.tag = tag; x.mv = '0; x.mh = '0;
    for (int e = 0; e < GRID; e++) begin
      for (int s = 0; s < GRID; s++) begin
        logic [2:0] gv, gh;
        gv = grade((e == 0) ? s_left[s] : s_cur[s*GRID+e-1], s_cur[s*GRID+e], e == 0, kept(0, e));
        gh = grade((e == 0) ? s_top[s] : s_cur[(e-1)*GRID+s], s_cur[e*GRID+s], e == 0, kept(1, e));
        x.v[(e*GRID+s)*3 +: 3] = gv;
        x.h[(e*GRID+s)*3 +: 3] = gh;
        if (gv != 0) x.mv[e] = 1'b1;
        if (gh != 0) x.mh[e] = 1'b1;
      end
    end
    exp_q.push_back(x);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic clear();
    for (int b = 0; b < NSEG; b++) s_cur[b] = '0;
    for (int r = 0; r < GRID; r++) begin s_left[r] = '0; s_top[r] = '0; end
    s_lav = 1; s_tav = 1; s_skip = 0; s_cbp0 = 0; s_shape = 2'd0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t x;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected out_valid got 1 exp 0");
      end else begin
        x = exp_q.pop_front();
        if (bs_v !== x.v || bs_h !== x.h || edge_mask_v !== x.mv || edge_mask_h !== x.mh) begin
          errors++;
          $display("FAIL %s got v=%h h=%h mv=%b mh=%b exp v=%h h=%h mv=%b mh=%b",
                   x.tag, bs_v, bs_h, edge_mask_v, edge_mask_h, x.v, x.h, x.mv, x.mh);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [BSVW-1:0] hv, hh;
    rst_n = 0; in_valid = 0; cur_blk = '0; left_blk = '0; top_blk = '0;
    left_avail = 0; top_avail = 0; mb_skip = 0; cbp_zero = 0; part_shape = 0;
    clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || bs_v !== '0 || bs_h !== '0 || edge_mask_v !== '0 || edge_mask_h !== '0) begin
      errors++;
      $display("FAIL R12 reset state got vld=%b v=%h h=%h exp all zero", out_valid, bs_v, bs_h);
    end

    clear(); send("R6 all quiet");
    clear(); s_cur[5] = mk(1, 0, 0, 0, 0); send("R2 internal intra");
    clear(); s_left[2] = mk(1, 0, 0, 0, 0); s_top[1] = mk(1, 1, 0, 0, 0); send("R1 boundary intra");
    clear(); s_top[3] = mk(0, 1, 0, 0, 0); s_cur[10] = mk(0, 1, 0, 0, 0); send("R3 residual");
    clear(); s_cur[6] = mk(0, 0, 0, 0, 1); s_left[0] = mk(0, 0, 0, 0, 2); send("R4 reference differs");
    clear(); s_cur[0] = mk(0, 0, 4, 0, 0); s_cur[15] = mk(0, 0, 0, -3, 0); s_cur[9] = mk(0, 0, 0, -4, 0);
    send("R5 motion threshold");
    clear(); s_cur[4] = mk(1, 1, 8, 8, 3); s_cur[0] = mk(0, 1, 0, 0, 0); send("R6 priority order");
    idle();
    clear(); s_lav = 0; s_left[1] = mk(1, 0, 0, 0, 0); s_top[0] = mk(1, 0, 0, 0, 0); send("R7 left missing");
    clear(); s_tav = 0; s_top[2] = mk(0, 1, 0, 0, 0); s_left[3] = mk(0, 1, 0, 0, 0); send("R7 top missing");
    clear(); s_skip = 1; s_cur[5] = mk(0, 0, 12, 0, 1); s_left[1] = mk(0, 0, -8, 0, 0); send("R8 skip");
    clear(); s_cbp0 = 1; s_shape = 2'd1;
    for (int b = 0; b < NSEG; b++) s_cur[b] = mk(0, 0, (b % 4) * 5, (b / 4) * 5, 0);
    send("R9 16x8 bare");
    s_shape = 2'd2; send("R9 8x16 bare");
    s_shape = 2'd0; send("R9 16x16 bare kept");
    s_shape = 2'd1; s_cbp0 = 0; send("R9 16x8 coded kept");
    clear(); s_cur[3] = mk(0, 0, 0, 0, 1); send("R10 single edge mask");

    for (int n = 0; n < 40; n++) begin
      clear();
      for (int b = 0; b < NSEG; b++)
        s_cur[b] = mk(($urandom % 12) == 0, ($urandom % 6) == 0, int'($urandom % 13) - 6, int'($urandom % 13) - 6, int'($urandom % 2));
      for (int r = 0; r < GRID; r++) begin
        s_left[r] = mk(($urandom % 6) == 0, ($urandom % 5) == 0, int'($urandom % 13) - 6, 0, int'($urandom % 2));
        s_top[r]  = mk(($urandom % 6) == 0, ($urandom % 5) == 0, 0, int'($urandom % 13) - 6, int'($urandom % 2));
      end
      s_lav = ($urandom % 4) != 0; s_tav = ($urandom % 4) != 0;
      s_skip = ($urandom % 5) == 0; s_cbp0 = ($urandom % 2) == 0; s_shape = 2'($urandom % 4);
      send("R11 mixed stream");
      if (n % 7 == 3) idle();
    end
    idle();
    repeat (3) @(negedge clk);

    hv = bs_v; hh = bs_h;
    @(negedge clk);
    for (int b = 0; b < NSEG; b++) cur_blk[b*BLKW +: BLKW] = mk(1, 1, 40, 40, 5);
    left_avail = 1; top_avail = 1; mb_skip = 0; cbp_zero = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || bs_v !== hv || bs_h !== hh) begin
      errors++;
      $display("FAIL R11 idle hold got vld=%b v=%h exp vld=0 v=%h", out_valid, bs_v, hv);
    end

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 results missing got %0d pending exp 0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule